// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational binary adder. It takes two operand words and a carry input and returns their sum and a carry output. The default word is 20 bits wide. The word is cut into groups whose widths grow by one bit from the bottom group to the top: 2, 3, 4, 5 and 6 bits at the default sizes.

The lowest group is a plain ripple chain driven by the external carry. Each higher group computes two results in parallel. One result assumes an incoming carry of 0 and the other assumes 1. When the true carry arrives from the group below, a multiplexer keeps the sum bits and the carry out of the matching result. The groups get wider towards the top because a higher group waits longer for its select. That extra time lets it ripple through more bits, so the internal ripple and the select path finish at about the same time.

The adder sits in a datapath wherever a single-cycle add is needed and a full prefix tree would cost too much area. No clock is involved.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, {c_out, sum_out} equals a_in + b_in + c_in, computed as a (WIDTH+1)-bit unsigned sum.
- R2: The groups cover bits 0-1, 2-4, 5-8, 9-13 and 14-19. The lowest group ripples directly from c_in. A carry produced below any group boundary reaches the bits above it, at bit positions 2, 5, 9 and 14.
- R3: In every upper group, the candidate result that assumes a carry-in of 1, taken as {carry, sum}, equals the carry-in-0 candidate plus one.
- R4: In every upper group, the carry-in-1 candidate's carry out is never 0 while the carry-in-0 candidate's carry out is 1.
- R5: When every bit of a group has propagate set (the operand bits differ), that group's carry out equals the carry entering it.
- R6: All-ones plus zero with c_in = 1 gives sum_out = 0 and c_out = 1. All-ones plus all-ones with c_in = 1 gives all ones and c_out = 1.
- R7: Zero plus zero gives sum_out = 0 and c_out = 0 with c_in = 0. With c_in = 1 it gives sum_out = 1 and c_out = 0.
- R8: c_out is the carry out of bit 19, which is the selected carry of the top group. For example, 0x80000 + 0x80000 gives sum_out = 0 and c_out = 1.
- R9: The alternating patterns 0x55555 + 0xAAAAA give 0xFFFFF with c_out = 0 when c_in = 0. They give 0 with c_out = 1 when c_in = 1.
- R10: The outputs depend only on the present inputs. A new input is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The select carry coming from below and a group's own internal ripple can both run the full length of the word for the same input. In that case every multiplexer switches on a carry that was itself chosen by the multiplexer below it. The bench provokes this with operands whose propagate bits span every group boundary: all ones plus a carry-in, alternating patterns, and a single generate bit placed under a chain of propagates. It judges the result against an arithmetic sum computed in the bench. The candidate-pair assertions check on every vector that the two parallel chains in each group stay exactly one apart.

// File: rtl/adder_pkg.sv
package adder_pkg;

    // Per-bit setup signals
    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } bitsig_t;

    // Lowest bit of group k when group widths grow by one from "first"
    function automatic int grp_lo(input int k, input int first);
        return k * first + (k * (k - 1)) / 2;
    endfunction

    // Number of groups needed to cover "width" bits
    function automatic int grp_count(input int width, input int first);
        int n;
        n = 0;
        for (int k = 0; k < width; k++) begin
            if (grp_lo(k, first) < width) n = k + 1;
        end
        return n;
    endfunction

    // Width of group k, with the top group clipped to the word
    function automatic int grp_w(input int k, input int width, input int first);
        int hi;
        hi = grp_lo(k + 1, first);
        if (hi > width) hi = width;
        return hi - grp_lo(k, first);
    endfunction

endpackage

// File: rtl/bit_setup.sv
module bit_setup
    import adder_pkg::*;
#(
    parameter int W = 20
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output bitsig_t [W-1:0] sig
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sig[i].gen  = a[i] & b[i];
        assign sig[i].prop = a[i] ^ b[i];
        assign sig[i].kill = ~a[i] & ~b[i];
    end

endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic [W-1:0] kill,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] c;

    // Carry passes whenever the bit is not a delete bit; the sum uses the xor propagate
    always_comb begin
        c[0] = cin;
        for (int i = 0; i < W; i++) begin
            c[i+1] = gen[i] | (~kill[i] & c[i]);
            sum[i] = prop[i] ^ c[i];
        end
    end

    assign cout = c[W];

endmodule

// File: rtl/select_group.sv
module select_group #(
    parameter int W = 3
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic [W-1:0] kill,
    input  logic         csel,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] s_zero, s_one;
    logic         c_zero, c_one;

    ripple_chain #(.W(W)) u_chain0 (
        .prop(prop), .gen(gen), .kill(kill), .cin(1'b0),
        .sum(s_zero), .cout(c_zero)
    );

    ripple_chain #(.W(W)) u_chain1 (
        .prop(prop), .gen(gen), .kill(kill), .cin(1'b1),
        .sum(s_one), .cout(c_one)
    );

    always_comb begin
        if (csel) begin
            sum  = s_one;
            cout = c_one;
        end else begin
            sum  = s_zero;
            cout = c_zero;
        end
    end

    always_comb begin
        AST_PAIR_STEP: assert ({c_one, s_one} == ({c_zero, s_zero} + (W+1)'(1))); // R3
        AST_CHAIN_ORDER: assert (!(c_zero && !c_one)); // R4
        if (&prop) begin
            AST_GROUP_SKIP: assert (cout == csel); // R5
        end
    end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
    import adder_pkg::*;
#(
    parameter int WIDTH   = 20,
    parameter int FIRST_W = 2
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out
);

    localparam int NGRP = grp_count(WIDTH, FIRST_W);

    bitsig_t [WIDTH-1:0] sig;
    logic    [WIDTH-1:0] p_v, g_v, k_v;
    logic    [NGRP:0]    gcarry;

    bit_setup #(.W(WIDTH)) u_setup (
        .a(a_in), .b(b_in), .sig(sig)
    );

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            p_v[i] = sig[i].prop;
            g_v[i] = sig[i].gen;
            k_v[i] = sig[i].kill;
        end
    end

    assign gcarry[0] = c_in;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int LO = grp_lo(k, FIRST_W);
        localparam int GW = grp_w(k, WIDTH, FIRST_W);
        if (k == 0) begin : g_base
            // R2: lowest group ripples straight from the carry input
            ripple_chain #(.W(GW)) u_base (
                .prop(p_v[LO +: GW]), .gen(g_v[LO +: GW]), .kill(k_v[LO +: GW]),
                .cin(gcarry[k]), .sum(sum_out[LO +: GW]), .cout(gcarry[k+1])
            );
        end else begin : g_sel
            select_group #(.W(GW)) u_sel (
                .prop(p_v[LO +: GW]), .gen(g_v[LO +: GW]), .kill(k_v[LO +: GW]),
                .csel(gcarry[k]), .sum(sum_out[LO +: GW]), .cout(gcarry[k+1])
            );
        end
    end

    assign c_out = gcarry[NGRP];

    always_comb begin
        AST_SUM_TOTAL: assert ({c_out, sum_out} ==
            ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in})); // R1
    end

endmodule

// File: tb/sim_sqrt_csel_adder.sv
module sim_sqrt_csel_adder;

    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b, s;
    logic         ci, co;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    sqrt_csel_adder u0 (
        .a_in(a), .b_in(b), .c_in(ci), .sum_out(s), .c_out(co)
    );

    function automatic logic [W:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    // Drive after a rising edge, sample at the falling edge
    task automatic apply_check(input string req, input logic [W-1:0] x,
                               input logic [W-1:0] y, input logic c);
        logic [W:0] exp;
        @(posedge clk);
        a = x; b = y; ci = c;
        exp = ref_sum(x, y, c);
        @(negedge clk);
        total++;
        if ({co, s} !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h ci=%b got=%h exp=%h", req, x, y, c, {co, s}, exp);
        end
    endtask

    task automatic t_reset_state;
        apply_check("R7 reset zero", '0, '0, 1'b0);
    endtask

    task automatic t_zero;
        apply_check("R7 zero", '0, '0, 1'b0);
        apply_check("R7 zero cin", '0, '0, 1'b1);
    endtask

    task automatic t_all_ones;
        apply_check("R6 ones+cin", '1, '0, 1'b1);
        apply_check("R6 ones+ones", '1, '1, 1'b1);
    endtask

    task automatic t_top_carry;
        apply_check("R8 top carry", 20'h80000, 20'h80000, 1'b0);
        apply_check("R8 top chain", 20'hC0000, 20'h40000, 1'b1);
    endtask

    task automatic t_alternating;
        apply_check("R9 alt", 20'h55555, 20'hAAAAA, 1'b0);
        apply_check("R9 alt cin", 20'h55555, 20'hAAAAA, 1'b1);
        apply_check("R9 alt same", 20'h55555, 20'h55555, 1'b1);
    endtask

    task automatic t_boundaries;
        // A generate just below each boundary, propagates above it
        int bnd[4] = '{2, 5, 9, 14};
        foreach (bnd[i]) begin
            logic [W-1:0] x, y;
            x = '1 << (bnd[i] - 1);
            y = 20'(1) << (bnd[i] - 1);
            apply_check("R2 boundary", x, y, 1'b0);
            apply_check("R2 boundary cin", ~(20'(1) << bnd[i]), 20'(1) << bnd[i], 1'b1);
        end
    endtask

    task automatic t_skip;
        // Each group all-propagate; the carry must pass through unchanged
        apply_check("R5 skip cin1", 20'hF0F0F, 20'h0F0F0, 1'b1);
        apply_check("R5 skip cin0", 20'hF0F0F, 20'h0F0F0, 1'b0);
        apply_check("R5 skip gen", 20'hFFFFE, 20'h00003, 1'b0);
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = W'($urandom);
            apply_check("R1 R3 R4 random", x, y, 1'($urandom));
        end
    endtask

    task automatic t_no_clock;
        // R10: the output follows the input with no clock edge in between
        logic [W:0] exp;
        @(negedge clk);
        a = 20'h12345; b = 20'h0FEDC; ci = 1'b1;
        exp = ref_sum(20'h12345, 20'h0FEDC, 1'b1);
        #2;
        total++;
        if ({co, s} !== exp) begin
            bad++;
            $display("FAIL R10 got=%h exp=%h", {co, s}, exp);
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_zero();
        t_all_ones();
        t_top_carry();
        t_alternating();
        t_boundaries();
        t_skip();
        t_no_clock();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule